// File: doc/BRIEF.md
# CAN Bit Timing and Sampling Unit

This block turns a system clock into the bit-time framing of a CAN node. A programmable prescaler divides the clock into time quanta. A three-state machine then walks every bit through a one-quantum synchronisation segment, a first phase segment that covers propagation and early phase, and a second phase segment. The receive line is sampled where the first phase segment ends. Sampling uses either a single sample or a majority vote over three samples. The block pulses a strobe at that point and another at the start of each bit, which is where a transmitter should launch its next bit.

Falling edges of the receive line (recessive 1 to dominant 0) keep the node aligned to other transmitters. While the bus is idle, such an edge restarts the bit immediately (hard synchronisation). During a frame, it moves the sample point by a bounded number of quanta (resynchronisation). Timing fields are plain inputs that are captured only while a load input is high.

The state machine has three states. ST_SYNC lasts one quantum and moves to ST_SEG1 on the quantum tick. ST_SEG1 counts quanta and, at the sample point, moves to ST_SEG2 and raises the sample strobe. ST_SEG2 counts quanta and, at the bit end, returns to ST_SYNC and raises the transmit strobe. From any state, a hard synchronisation forces ST_SYNC with the prescaler cleared.

Top module: `can_bit_timer`

## Requirements
- R1: One time quantum lasts 2 × (prescale + 1) clock cycles, where prescale (0 to 63) is the captured 6-bit divider field.
- R2: Every bit starts with a synchronisation segment exactly one quantum long.
- R3: The first phase segment lasts seg1_len + 1 quanta (valid seg1_len 2 to 15). It lasts two quanta more when three-sample mode is captured.
- R4: The second phase segment lasts seg2_len + 1 quanta (valid seg2_len 1 to 7). An undisturbed bit therefore lasts 2 × (prescale + 1) × (3 + seg1_len + seg2_len) cycles, plus 2 × (prescale + 1) × 2 cycles in three-sample mode.
- R5: `sample_stb` is a one-cycle pulse in the cycle after the last clock of the first phase segment. `rx_bit` takes its new value in that same cycle and holds it otherwise.
- R6: `tx_stb` is a one-cycle pulse in the first clock of the synchronisation segment that follows a normal bit end. A hard synchronisation never produces it.
- R7: In single-sample mode, `rx_bit` is `rx_in` on the last clock of the first phase segment. In three-sample mode, it is the majority of that value and the values on the last clocks of the two quanta before it.
- R8: A resynchronising edge in the first phase segment, seen in its quantum q (counting from 0), lengthens that segment by min(q, jump_width + 1) quanta.
- R9: A resynchronising edge in the second phase segment, seen in its quantum q, shortens that segment by min(seg2_len − q, jump_width + 1) quanta. Here seg2_len − q is the number of whole quanta left after the edge's quantum.
- R10: An edge is a cycle where `rx_in` is 0 (dominant) after 1 (recessive) in the previous cycle. Rising edges, edges inside the synchronisation segment, a second edge in the same bit, and edges while `tx_dominant` is high cause no resynchronisation.
- R11: While `bus_idle` is high, an edge forces a hard synchronisation. The next cycle begins a fresh synchronisation segment with the quantum counter cleared, and any strobe due in the edge cycle is dropped.
- R12: Timing fields are captured only in cycles with `cfg_load` high. Reset selects prescale 0, seg1_len 2, seg2_len 1, jump_width 0 and single-sample mode, with both strobes low and `rx_bit` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Captures the timing fields in this cycle |
| prescale | input | 6 | Quantum divider field |
| seg1_len | input | 4 | First phase segment field |
| seg2_len | input | 3 | Second phase segment field |
| jump_width | input | 2 | Resynchronisation limit field |
| three_samp | input | 1 | 1 selects three-sample majority mode |
| bus_idle | input | 1 | High while no frame is on the bus; enables hard synchronisation |
| tx_dominant | input | 1 | High while this node drives a dominant bit |
| rx_in | input | 1 | Receive line, already synchronised to clk (0 dominant) |
| rx_bit | output | 1 | Last sampled bit value |
| sample_stb | output | 1 | Pulse marking a new `rx_bit` |
| tx_stb | output | 1 | Pulse at the start of each bit |

## Verification
The hard cases are an edge that arrives on the same clock as a quantum tick that also ends the first or second phase segment. In that cycle, the correction and the segment decision must take effect together. A hard synchronisation on such a tick must also drop the strobe that would otherwise have fired. The bench provokes these cases by placing a single falling edge at every clock offset across a whole bit, first with the node passive and then with it transmitting. It adds long runs of random line activity with `bus_idle` pulsing. A behavioural model judges every clock. Measured bit lengths confirm the lengthening, shortening and clipping at chosen offsets.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
    localparam int PRE_W = 6;   // quantum divider field width
    localparam int S1_W  = 4;   // first phase segment field width
    localparam int S2_W  = 3;   // second phase segment field width
    localparam int JW_W  = 2;   // jump width field width

    typedef enum logic [1:0] {
        ST_SYNC = 2'd0,
        ST_SEG1 = 2'd1,
        ST_SEG2 = 2'd2
    } seg_e;
endpackage

// File: rtl/cbt_tq_prescaler.sv
module cbt_tq_prescaler #(
    parameter int PRE_W = cbt_pkg::PRE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] prescale,
    input  logic             restart,
    output logic             tick
);
    localparam int DIV_W = PRE_W + 1;

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] last;

    // last count of a quantum is 2*(prescale+1)-1
    assign last = {prescale, 1'b1};
    assign tick = (cnt_q >= last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + DIV_W'(1);
    end

    // R1: a quantum is at least two clocks, so ticks never sit back to back
    p_tq_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/cbt_seg_fsm.sv
module cbt_seg_fsm import cbt_pkg::*; #(
    parameter int S1_W = cbt_pkg::S1_W,
    parameter int S2_W = cbt_pkg::S2_W,
    parameter int JW_W = cbt_pkg::JW_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            fall,
    input  logic            hard,
    input  logic            tx_dominant,
    input  logic [S1_W-1:0] seg1_len,
    input  logic [S2_W-1:0] seg2_len,
    input  logic [JW_W-1:0] jump_width,
    input  logic            three_samp,
    output seg_e            state,
    output logic            samp_pt,
    output logic            bit_end
);
    localparam int SEG_W = S1_W + 2;
    localparam logic [SEG_W-1:0] ONE = SEG_W'(1);

    seg_e             st_q, st_n;
    logic [SEG_W-1:0] q_q, q_n;
    logic [SEG_W-1:0] ext_q, ext_n;
    logic [SEG_W-1:0] shr_q, shr_n;
    logic             done_q, done_n;
    logic [SEG_W-1:0] jq, base2, err, corr, len1, len2;
    logic             resync_ok, end1, end2;

    // phase correction, applied in the cycle the edge is seen
    always_comb begin
        jq        = SEG_W'(jump_width) + ONE;
        base2     = SEG_W'(seg2_len) + ONE;
        resync_ok = fall && !hard && !tx_dominant && !done_q && (st_q != ST_SYNC);
        err       = (st_q == ST_SEG1) ? q_q : (base2 - shr_q - q_q - ONE);
        corr      = (err < jq) ? err : jq;
        ext_n     = ext_q;
        shr_n     = shr_q;
        done_n    = done_q;
        if (resync_ok) begin
            done_n = 1'b1;
            if (st_q == ST_SEG1)
                ext_n = ext_q + corr;
            else
                shr_n = shr_q + corr;
        end
        len1 = SEG_W'(seg1_len) + ONE + (three_samp ? SEG_W'(2) : SEG_W'(0)) + ext_n;
        len2 = base2 - shr_n;
        end1 = (q_q + ONE >= len1);
        end2 = (q_q + ONE >= len2);
    end

    // next state
    always_comb begin
        st_n = st_q;
        q_n  = q_q;
        if (hard) begin
            st_n = ST_SYNC;
            q_n  = '0;
        end else if (tick) begin
            unique case (st_q)
                ST_SYNC: begin
                    st_n = ST_SEG1;
                    q_n  = '0;
                end
                ST_SEG1: begin
                    if (end1) begin
                        st_n = ST_SEG2;
                        q_n  = '0;
                    end else begin
                        q_n = q_q + ONE;
                    end
                end
                ST_SEG2: begin
                    if (end2) begin
                        st_n = ST_SYNC;
                        q_n  = '0;
                    end else begin
                        q_n = q_q + ONE;
                    end
                end
                default: begin
                    st_n = ST_SYNC;
                    q_n  = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        samp_pt = !hard && tick && (st_q == ST_SEG1) && end1;
        bit_end = !hard && tick && (st_q == ST_SEG2) && end2;
        state   = st_q;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_SYNC;
            q_q    <= '0;
            ext_q  <= '0;
            shr_q  <= '0;
            done_q <= 1'b0;
        end else begin
            st_q <= st_n;
            q_q  <= q_n;
            if (hard || bit_end) begin
                ext_q  <= '0;
                shr_q  <= '0;
                done_q <= 1'b0;
            end else begin
                ext_q  <= ext_n;
                shr_q  <= shr_n;
                done_q <= done_n;
            end
        end
    end

    // R2: the sync segment ends after a single quantum
    p_sync_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SYNC) && tick && !hard |=> st_q == ST_SEG1);

    // R11: hard synchronisation restarts the bit
    p_hard_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hard |=> (st_q == ST_SYNC) && (q_q == '0));

    // R10: once a bit has been corrected, the correction is frozen
    p_one_resync_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_q && !bit_end && !hard |=> $stable(ext_q) && $stable(shr_q));
endmodule

// File: rtl/cbt_bit_sampler.sv
module cbt_bit_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_in,
    input  logic tick,
    input  logic in_seg1,
    input  logic hard,
    input  logic samp_pt,
    input  logic bit_end,
    input  logic three_samp,
    output logic fall,
    output logic rx_bit,
    output logic sample_stb,
    output logic tx_stb
);
    logic       prev_q;
    logic [1:0] hist_q;
    logic       vote;
    logic       bit_q, sstb_q, tstb_q;

    assign fall = prev_q & ~rx_in;
    assign vote = (hist_q[1] & hist_q[0]) | (hist_q[1] & rx_in) | (hist_q[0] & rx_in);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
            hist_q <= 2'b11;
            bit_q  <= 1'b1;
            sstb_q <= 1'b0;
            tstb_q <= 1'b0;
        end else begin
            prev_q <= rx_in;
            if (tick && in_seg1 && !hard)
                hist_q <= {hist_q[0], rx_in};
            if (samp_pt)
                bit_q <= three_samp ? vote : rx_in;
            sstb_q <= samp_pt;
            tstb_q <= bit_end;
        end
    end

    assign rx_bit     = bit_q;
    assign sample_stb = sstb_q;
    assign tx_stb     = tstb_q;

    // R5: sample point and bit start are never the same cycle
    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(sstb_q && tstb_q));
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer import cbt_pkg::*; #(
    parameter int PRE_W = cbt_pkg::PRE_W,
    parameter int S1_W  = cbt_pkg::S1_W,
    parameter int S2_W  = cbt_pkg::S2_W,
    parameter int JW_W  = cbt_pkg::JW_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic [PRE_W-1:0] prescale,
    input  logic [S1_W-1:0]  seg1_len,
    input  logic [S2_W-1:0]  seg2_len,
    input  logic [JW_W-1:0]  jump_width,
    input  logic             three_samp,
    input  logic             bus_idle,
    input  logic             tx_dominant,
    input  logic             rx_in,
    output logic             rx_bit,
    output logic             sample_stb,
    output logic             tx_stb
);
    logic [PRE_W-1:0] pre_q;
    logic [S1_W-1:0]  s1_q;
    logic [S2_W-1:0]  s2_q;
    logic [JW_W-1:0]  jw_q;
    logic             three_q;

    logic tick, fall, hard, samp_pt, bit_end;
    seg_e seg_st;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q   <= '0;
            s1_q    <= S1_W'(2);
            s2_q    <= S2_W'(1);
            jw_q    <= '0;
            three_q <= 1'b0;
        end else if (cfg_load) begin
            pre_q   <= prescale;
            s1_q    <= seg1_len;
            s2_q    <= seg2_len;
            jw_q    <= jump_width;
            three_q <= three_samp;
        end
    end

    assign hard = fall & bus_idle;

    cbt_tq_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .prescale (pre_q),
        .restart  (hard),
        .tick     (tick)
    );

    cbt_seg_fsm #(.S1_W(S1_W), .S2_W(S2_W), .JW_W(JW_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .fall        (fall),
        .hard        (hard),
        .tx_dominant (tx_dominant),
        .seg1_len    (s1_q),
        .seg2_len    (s2_q),
        .jump_width  (jw_q),
        .three_samp  (three_q),
        .state       (seg_st),
        .samp_pt     (samp_pt),
        .bit_end     (bit_end)
    );

    cbt_bit_sampler u_smp (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_in      (rx_in),
        .tick       (tick),
        .in_seg1    (seg_st == ST_SEG1),
        .hard       (hard),
        .samp_pt    (samp_pt),
        .bit_end    (bit_end),
        .three_samp (three_q),
        .fall       (fall),
        .rx_bit     (rx_bit),
        .sample_stb (sample_stb),
        .tx_stb     (tx_stb)
    );

    // R6: the transmit strobe always falls inside the sync segment
    p_tx_in_sync_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stb |-> seg_st == ST_SYNC);
endmodule

// File: tb/tb_can_bit_timer.sv
module tb_can_bit_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_load = 1'b0;
    logic [5:0] prescale = '0;
    logic [3:0] seg1_len = 4'd2;
    logic [2:0] seg2_len = 3'd1;
    logic [1:0] jump_width = '0;
    logic       three_samp = 1'b0;
    logic       bus_idle = 1'b0;
    logic       tx_dominant = 1'b0;
    logic       rx_in = 1'b1;
    logic       rx_bit, sample_stb, tx_stb;

    int checks = 0;
    int errs = 0;
    bit finished = 0;
    string cur_req = "R12 reset";
    int b_p = 0, b_s1 = 2, b_s2 = 1, b_th = 0;

    always #5 clk = ~clk;

    can_bit_timer dut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .prescale(prescale),
        .seg1_len(seg1_len), .seg2_len(seg2_len), .jump_width(jump_width),
        .three_samp(three_samp), .bus_idle(bus_idle), .tx_dominant(tx_dominant),
        .rx_in(rx_in), .rx_bit(rx_bit), .sample_stb(sample_stb), .tx_stb(tx_stb)
    );

    // ---------------- behavioural reference model ----------------
    int m_pre, m_s1, m_s2, m_jw, m_th;
    int m_pc, m_st, m_q, m_ext, m_shr, m_done;
    int m_prev, m_h1, m_h0, m_bit, m_sstb, m_tstb;

    function automatic int imin(int a, int b);
        return (a < b) ? a : b;
    endfunction

    always @(posedge clk) begin : model
        int plen, l1, l2, jq, e;
        bit tk, fl, hd, ok;
        if (!rst_n) begin
            m_pre = 0; m_s1 = 2; m_s2 = 1; m_jw = 0; m_th = 0;
            m_pc = 0; m_st = 0; m_q = 0; m_ext = 0; m_shr = 0; m_done = 0;
            m_prev = 1; m_h1 = 1; m_h0 = 1; m_bit = 1; m_sstb = 0; m_tstb = 0;
        end else begin
            plen = 2 * (m_pre + 1);
            tk = (m_pc >= plen - 1);
            fl = (m_prev == 1) && (rx_in == 1'b0);
            hd = fl && bus_idle;
            m_sstb = 0;
            m_tstb = 0;
            if (hd) begin
                m_pc = 0; m_st = 0; m_q = 0; m_ext = 0; m_shr = 0; m_done = 0;
            end else begin
                ok = fl && !tx_dominant && (m_done == 0) && (m_st != 0);
                jq = m_jw + 1;
                if (ok) begin
                    if (m_st == 1) m_ext += imin(m_q, jq);
                    else begin
                        e = m_s2 - m_q;
                        m_shr += imin(e, jq);
                    end
                    m_done = 1;
                end
                l1 = m_s1 + 1 + (m_th ? 2 : 0) + m_ext;
                l2 = m_s2 + 1 - m_shr;
                if (tk) begin
                    m_pc = 0;
                    if (m_st == 0) begin
                        m_st = 1; m_q = 0;
                    end else if (m_st == 1) begin
                        if (m_q + 1 >= l1) begin
                            m_sstb = 1;
                            m_bit = m_th ? ((m_h1 + m_h0 + int'(rx_in)) >= 2) : int'(rx_in);
                            m_st = 2; m_q = 0;
                        end else m_q++;
                        m_h1 = m_h0;
                        m_h0 = int'(rx_in);
                    end else begin
                        if (m_q + 1 >= l2) begin
                            m_tstb = 1; m_st = 0; m_q = 0;
                            m_ext = 0; m_shr = 0; m_done = 0;
                        end else m_q++;
                    end
                end else begin
                    m_pc++;
                end
            end
            m_prev = int'(rx_in);
            if (cfg_load) begin
                m_pre = prescale; m_s1 = seg1_len; m_s2 = seg2_len;
                m_jw = jump_width; m_th = three_samp;
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            checks++;
            if (sample_stb !== m_sstb[0] || tx_stb !== m_tstb[0] || rx_bit !== m_bit[0]) begin
                errs++;
                $display("FAIL %s stb/tx/bit actual=%b%b%b expected=%0d%0d%0d",
                         cur_req, sample_stb, tx_stb, rx_bit, m_sstb, m_tstb, m_bit);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic expect_int(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic setcfg(int p, int s1, int s2, int jw, int th);
        @(negedge clk);
        prescale = 6'(p); seg1_len = 4'(s1); seg2_len = 3'(s2);
        jump_width = 2'(jw); three_samp = th[0]; cfg_load = 1'b1;
        b_p = p; b_s1 = s1; b_s2 = s2; b_th = th;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    function automatic int nominal();
        return 2 * (b_p + 1) * (3 + b_s1 + b_s2 + (b_th != 0 ? 2 : 0));
    endfunction

    task automatic wait_tx();
        do @(negedge clk); while (tx_stb !== 1'b1);
    endtask

    task automatic measure(output int len);
        wait_tx();
        len = 0;
        do begin @(negedge clk); len++; end while (tx_stb !== 1'b1);
    endtask

    // one bit with falling edges driven at clock offsets a and b (b<0: none)
    task automatic edge_bit(int a, int b, output int len);
        wait_tx();
        len = 0;
        do begin
            if (len == a || len == b) rx_in = 1'b0;
            if (len == a + 2 || len == b + 2) rx_in = 1'b1;
            @(negedge clk);
            len++;
        end while (tx_stb !== 1'b1);
        rx_in = 1'b1;
    endtask

    task automatic random_run(int n, bit idle_pulses);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if ($urandom_range(7) == 0) rx_in = ~rx_in;
            bus_idle = idle_pulses && ($urandom_range(40) == 0);
        end
        bus_idle = 1'b0;
        rx_in = 1'b1;
    endtask

    // ---------------- stimulus ----------------
    initial begin
        int len;
        repeat (3) @(negedge clk);
        cur_req = "R12 reset";
        expect_int("R12 reset sample_stb", int'(sample_stb), 0);
        expect_int("R12 reset tx_stb", int'(tx_stb), 0);
        expect_int("R12 reset rx_bit", int'(rx_bit), 1);
        rst_n = 1'b1;

        cur_req = "R12 reset period";
        measure(len);
        expect_int("R12 default bit length", len, nominal());

        cur_req = "R1 R2 R4 timing";
        setcfg(1, 3, 2, 1, 0);
        wait_tx();
        measure(len);
        expect_int("R1 R4 bit length", len, 32);

        cur_req = "R12 no load";
        @(negedge clk);
        prescale = 6'd9; seg1_len = 4'd12; seg2_len = 3'd6; jump_width = 2'd3;
        measure(len);
        expect_int("R12 fields ignored without load", len, 32);
        prescale = 6'd1; seg1_len = 4'd3; seg2_len = 3'd2; jump_width = 2'd1;

        cur_req = "R11 hard sync";
        bus_idle = 1'b1;
        repeat (7) @(negedge clk);
        len = 0;
        rx_in = 1'b0;
        do begin
            if (len == 2) rx_in = 1'b1;
            @(negedge clk);
            len++;
        end while (tx_stb !== 1'b1);
        rx_in = 1'b1;
        expect_int("R11 R6 hard sync to first tx_stb", len, 33);
        bus_idle = 1'b0;

        cur_req = "R8 lengthen";
        edge_bit(9, -1, len);
        expect_int("R8 edge in seg1 quantum 1", len, 36);
        edge_bit(13, -1, len);
        expect_int("R8 edge in seg1 quantum 2", len, 40);
        edge_bit(17, -1, len);
        expect_int("R8 clipped to jump width", len, 40);

        cur_req = "R9 shorten";
        edge_bit(20, -1, len);
        expect_int("R9 edge in seg2 quantum 0", len, 24);
        edge_bit(24, -1, len);
        expect_int("R9 edge in seg2 quantum 1", len, 28);
        edge_bit(28, -1, len);
        expect_int("R9 edge in last quantum", len, 32);

        cur_req = "R10 ignored edges";
        for (int off = 0; off < 4; off++) begin
            edge_bit(off, -1, len);
            expect_int("R10 edge in sync segment", len, 32);
        end
        edge_bit(9, 20, len);
        expect_int("R10 second edge in one bit", len, 36);
        tx_dominant = 1'b1;
        for (int off = 0; off < 32; off++) begin
            edge_bit(off, -1, len);
            expect_int("R10 edge while transmitting dominant", len, 32);
        end
        tx_dominant = 1'b0;

        cur_req = "R8 R9 sweep wide jump";
        setcfg(1, 3, 2, 3, 0);
        wait_tx();
        for (int off = 0; off < 32; off++) edge_bit(off, -1, len);

        cur_req = "R3 R4 three-sample length";
        setcfg(0, 4, 2, 3, 1);
        wait_tx();
        measure(len);
        expect_int("R3 R4 three-sample bit length", len, nominal());

        cur_req = "R7 majority vote";
        tx_dominant = 1'b1;
        random_run(2500, 1'b0);
        tx_dominant = 1'b0;
        cur_req = "R7 R8 R9 three-sample with sync";
        random_run(2500, 1'b0);

        cur_req = "R5 R6 R11 single-sample random";
        setcfg(2, 5, 3, 2, 0);
        wait_tx();
        wait_tx();
        random_run(4000, 1'b1);
        repeat (5) @(negedge clk);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errs++;
            $display("FAIL R1 watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errs);
            $finish;
        end
    end
endmodule